// File: doc/BRIEF.md
# Channel-Programmed PLL Divider Chain

This block is the digital part of a fixed-channel frequency synthesizer. Three select pins each take one of three states, so the board fixes the pin levels rather than software. The block decodes them into one of fifteen channels and looks up a 14-bit main divide ratio for that channel. Two ratio columns exist, one for each of two slightly different crystal frequencies, and a separate input picks the column.

The reference clock passes through a prescaler that divides by 1 or by 2, then a fixed divide-by-286, to reach the comparison rate of about 25 kHz. The oscillator feedback clock goes through the programmable main divider. A phase-frequency detector compares the two divided streams and produces up and down pulses for an external charge pump.

Both the reference clock and the feedback clock are oversampled by the core clock `clk_i`. Each one is synchronised, and its rising edges act as count enables. Everything in the block therefore runs in a single clock domain. Each input clock must stay below half the core clock rate.

Top module: `chan_pll_core`

## Requirements
- R1: Pin codes are open=0, low=1, high=2. Channel n (1..15) has k=n-1 with `sel_a_i`=k mod 3, `sel_b_i`=(k div 3) mod 3 and `sel_c_i`=k div 9. `chan_o` shows n and `invalid_o` is 0 one clock after the pins settle.
- R2: A pin combination that maps to no channel drives `invalid_o`=1 and `chan_o`=0 one clock later. This covers any code 3, `sel_c_i`=2, or `sel_c_i`=1 with `sel_b_i`=2.
- R3: While `invalid_o` is 1, `up_o` and `dn_o` are 0 from the next clock. Divided edges that arrive during this time leave no pending pulse once a valid channel returns.
- R4: With `xtal_sel_i`=0, channels 1..15 divide by 1705, 3345, 3925, 3997, 4324, 4684, 4708, 4764, 5331, 5563, 6742, 7202, 8443, 8756, 12497.
- R5: With `xtal_sel_i`=1, channels 1..15 divide by 1704, 3344, 3923, 3995, 4323, 4682, 4706, 4762, 5329, 5561, 6739, 7199, 8439, 8753, 12492.
- R6: The reference path divides rising reference edges by 286 when `rate_sel_i`=0 and by 572 when `rate_sel_i`=1.
- R7: After reset, the first counted edge of each divider loads its ratio. The terminal count follows that many edges later, so the first `dn_o` comes on feedback edge N+1 and the first `up_o` on divided-reference edge 287. A change of channel or column takes effect only at the next terminal count.
- R8: A reference terminal count sets `up_o` and a feedback terminal count sets `dn_o`. Each one holds until both are high. When both are high they clear after one clock, except that a terminal count in that same cycle sets its own output again.
- R9: While `rst_ni` is low, `up_o`=0, `dn_o`=0, `chan_o`=0 and `invalid_o`=1, and all counters return to their unloaded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples both input clocks |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock |
| osc_clk_i | input | 1 | Oscillator feedback clock |
| sel_a_i | input | 2 | First channel pin state (fastest-changing) |
| sel_b_i | input | 2 | Second channel pin state |
| sel_c_i | input | 2 | Third channel pin state |
| rate_sel_i | input | 1 | 1 selects the double-rate reference (prescale by 2) |
| xtal_sel_i | input | 1 | Chooses the ratio column |
| up_o | output | 1 | Phase detector up pulse |
| dn_o | output | 1 | Phase detector down pulse |
| chan_o | output | 4 | Decoded channel, 0 when invalid |
| invalid_o | output | 1 | Pin combination maps to no channel |

## Verification
The bench sweeps all 64 pin codes. A decoder with the wrong digit weights or a loose bound would assign channels to illegal codes, such as channel 16 or the third pin high. It counts single feedback and reference edges up to the first terminal count in both prescale modes and both ratio columns. An off-by-one reload, a skipped prescale phase or a swapped column then shows up as an early or late pulse on exactly one edge. A mid-count channel change must not cut the running count short: a divider that reloads on the change would fire early. A behavioural model also follows every output on every clock through free-running traffic, including an invalid stretch, where a detector that keeps stale edges would pulse after the channel returns.

// File: rtl/chan_pll_pkg.sv
package chan_pll_pkg;
  localparam int SEL_W    = 2;
  localparam int CHAN_W   = 4;
  localparam int NUM_CHAN = 15;
  localparam int RATIO_W  = 14;
  localparam int REF_DIV  = 286;
  localparam int IDX_W    = 6;

  typedef logic [SEL_W-1:0]   pin_code_t;
  typedef logic [CHAN_W-1:0]  chan_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  localparam pin_code_t PIN_OPEN = 2'd0;
  localparam pin_code_t PIN_LOW  = 2'd1;
  localparam pin_code_t PIN_HIGH = 2'd2;

  // alt selects the second crystal column; channel 0 yields 0 (divider idles)
  function automatic ratio_t main_ratio(chan_t ch, logic alt);
    case (ch)
      4'd1:    return alt ? 14'd1704  : 14'd1705;
      4'd2:    return alt ? 14'd3344  : 14'd3345;
      4'd3:    return alt ? 14'd3923  : 14'd3925;
      4'd4:    return alt ? 14'd3995  : 14'd3997;
      4'd5:    return alt ? 14'd4323  : 14'd4324;
      4'd6:    return alt ? 14'd4682  : 14'd4684;
      4'd7:    return alt ? 14'd4706  : 14'd4708;
      4'd8:    return alt ? 14'd4762  : 14'd4764;
      4'd9:    return alt ? 14'd5329  : 14'd5331;
      4'd10:   return alt ? 14'd5561  : 14'd5563;
      4'd11:   return alt ? 14'd6739  : 14'd6742;
      4'd12:   return alt ? 14'd7199  : 14'd7202;
      4'd13:   return alt ? 14'd8439  : 14'd8443;
      4'd14:   return alt ? 14'd8753  : 14'd8756;
      4'd15:   return alt ? 14'd12492 : 14'd12497;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], lvl_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/chan_decode.sv
module chan_decode
  import chan_pll_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_code_t sel_a_i,
  input  pin_code_t sel_b_i,
  input  pin_code_t sel_c_i,
  output chan_t     chan_o,
  output logic      invalid_o
);
  localparam int RADIX = 3;

  logic [IDX_W-1:0] idx;
  logic             legal;
  chan_t            chan_q;
  logic             inv_q;

  always_comb begin
    idx   = IDX_W'(sel_a_i)
          + IDX_W'(sel_b_i) * IDX_W'(RADIX)
          + IDX_W'(sel_c_i) * IDX_W'(RADIX * RADIX);
    legal = (sel_a_i <= PIN_HIGH) && (sel_b_i <= PIN_HIGH) &&
            (sel_c_i <= PIN_LOW) && (idx < IDX_W'(NUM_CHAN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      inv_q  <= 1'b1;
    end else begin
      chan_q <= legal ? chan_t'(idx + IDX_W'(1)) : '0;
      inv_q  <= ~legal;
    end
  end

  assign chan_o    = chan_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/tc_divider.sv
module tc_divider #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o
);
  // rem_q: ticks left to terminal count; 0 = unloaded, ratio sampled only on reload
  logic [W-1:0] rem_q;
  logic         reload;

  assign reload = (rem_q <= W'(1));
  assign tc_o   = tick_i && (rem_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (tick_i) rem_q <= reload ? ratio_i : rem_q - W'(1);
  end
endmodule

// File: rtl/pfd.sv
module pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ref_tc_i,
  input  logic fb_tc_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (hold_i) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      up_q <= ref_tc_i;
      dn_q <= fb_tc_i;
    end else begin
      up_q <= up_q | ref_tc_i;
      dn_q <= dn_q | fb_tc_i;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/chan_pll_core.sv
module chan_pll_core
  import chan_pll_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       osc_clk_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  input  logic [1:0] sel_c_i,
  input  logic       rate_sel_i,
  input  logic       xtal_sel_i,
  output logic       up_o,
  output logic       dn_o,
  output logic [3:0] chan_o,
  output logic       invalid_o
);
  localparam int NUM_IN = 2;
  localparam int IN_REF = 0;
  localparam int IN_OSC = 1;
  localparam int REF_W  = $clog2(REF_DIV + 1);

  logic [NUM_IN-1:0] raw_lvl, rise;
  chan_t             chan;
  logic              inv;
  ratio_t            ratio;
  logic              pre_q, pre_tick;
  logic              ref_tc, fb_tc;

  assign raw_lvl[IN_REF] = ref_clk_i;
  assign raw_lvl[IN_OSC] = osc_clk_i;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (raw_lvl[g]),
      .rise_o (rise[g])
    );
  end

  chan_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_a_i   (sel_a_i),
    .sel_b_i   (sel_b_i),
    .sel_c_i   (sel_c_i),
    .chan_o    (chan),
    .invalid_o (inv)
  );

  assign ratio = main_ratio(chan, xtal_sel_i);

  // prescale: in double-rate mode pass every second reference edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pre_q <= 1'b0;
    else if (rise[IN_REF]) pre_q <= ~pre_q;
  end
  assign pre_tick = rise[IN_REF] & (~rate_sel_i | pre_q);

  tc_divider #(.W(REF_W)) u_ref_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (pre_tick),
    .ratio_i (REF_W'(REF_DIV)),
    .tc_o    (ref_tc)
  );

  tc_divider #(.W(RATIO_W)) u_fb_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (rise[IN_OSC]),
    .ratio_i (ratio),
    .tc_o    (fb_tc)
  );

  pfd u_pfd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (inv),
    .ref_tc_i (ref_tc),
    .fb_tc_i  (fb_tc),
    .up_o     (up_o),
    .dn_o     (dn_o)
  );

  assign chan_o    = chan;
  assign invalid_o = inv;
endmodule

// File: rtl/chan_pll_chk.sv
module chan_pll_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       up_o,
  input logic       dn_o,
  input logic [3:0] chan_o,
  input logic       invalid_o
);
  AST_CHAN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !invalid_o |-> (chan_o >= 4'd1 && chan_o <= 4'd15)); // R1
  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (chan_o == 4'd0)); // R2
  AST_IDLE_WHEN_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |=> (!up_o && !dn_o)); // R3
  AST_PAIR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> !(up_o && dn_o)); // R8
  AST_UP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && !dn_o && !invalid_o) |=> up_o); // R8
  AST_DN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_o && !up_o && !invalid_o) |=> dn_o); // R8
endmodule

bind chan_pll_core chan_pll_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_o      (up_o),
  .dn_o      (dn_o),
  .chan_o    (chan_o),
  .invalid_o (invalid_o)
);

// File: tb/sim_chan_pll_core.sv
`timescale 1ns/1ps
module sim_chan_pll_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0, osc_clk = 1'b0;
  logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0;
  logic       rate_sel = 1'b0, xtal_sel = 1'b0;
  logic       up, dn, invalid;
  logic [3:0] chan;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chan_pll_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .osc_clk_i(osc_clk),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .sel_c_i(sel_c),
    .rate_sel_i(rate_sel), .xtal_sel_i(xtal_sel),
    .up_o(up), .dn_o(dn), .chan_o(chan), .invalid_o(invalid)
  );

  localparam int COL0 [15] = '{1705, 3345, 3925, 3997, 4324, 4684, 4708, 4764,
                               5331, 5563, 6742, 7202, 8443, 8756, 12497};
  localparam int COL1 [15] = '{1704, 3344, 3923, 3995, 4323, 4682, 4706, 4762,
                               5329, 5561, 6739, 7199, 8439, 8753, 12492};

  function automatic int exp_chan(int a, int b, int c);
    for (int n = 1; n <= 15; n++)
      if ((n-1) % 3 == a && ((n-1) / 3) % 3 == b && (n-1) / 9 == c) return n;
    return 0;
  endfunction

  function automatic int exp_ratio(int n, bit alt);
    if (n < 1 || n > 15) return 0;
    return alt ? COL1[n-1] : COL0[n-1];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, advanced every clock
  int h1, h2, h3, q1, q2, q3, m_chan, m_inv, m_pre, m_rrem, m_frem, m_up, m_dn;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; q1 = 0; q2 = 0; q3 = 0;
      m_chan = 0; m_inv = 1; m_pre = 0; m_rrem = 0; m_frem = 0; m_up = 0; m_dn = 0;
    end else begin
      bit rp, op, pt, rtc, ftc;
      rp = (h2 == 1) && (h3 == 0);
      op = (q2 == 1) && (q3 == 0);
      pt = rp && (!rate_sel || m_pre == 1);
      rtc = pt && m_rrem == 1;
      if (pt) m_rrem = (m_rrem <= 1) ? 286 : m_rrem - 1;
      ftc = op && m_frem == 1;
      if (op) m_frem = (m_frem <= 1) ? exp_ratio(m_chan, xtal_sel) : m_frem - 1;
      if (rp) m_pre = 1 - m_pre;
      if (m_inv == 1) begin m_up = 0; m_dn = 0; end
      else if (m_up == 1 && m_dn == 1) begin m_up = int'(rtc); m_dn = int'(ftc); end
      else begin m_up = m_up | int'(rtc); m_dn = m_dn | int'(ftc); end
      m_chan = exp_chan(int'(sel_a), int'(sel_b), int'(sel_c));
      m_inv = (m_chan == 0) ? 1 : 0;
      h3 = h2; h2 = h1; h1 = int'(ref_clk);
      q3 = q2; q2 = q1; q1 = int'(osc_clk);
    end
  end

  always @(posedge clk) begin
    #1;
    if (!finished) begin
      check(int'(chan) == m_chan, "R1 model chan", int'(chan), m_chan);
      check(int'(invalid) == m_inv, "R2 model invalid", int'(invalid), m_inv);
      check(int'(up) == m_up, "R8 model up", int'(up), m_up);
      check(int'(dn) == m_dn, "R8 model dn", int'(dn), m_dn);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; ref_clk = 1'b0; osc_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic ref_edge();
    ref_clk = 1'b1; repeat (2) @(negedge clk);
    ref_clk = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic osc_edge();
    osc_clk = 1'b1; repeat (2) @(negedge clk);
    osc_clk = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic set_pins(int a, int b, int c);
    sel_a = 2'(a); sel_b = 2'(b); sel_c = 2'(c);
  endtask

  // count feedback edges to the first dn pulse
  task automatic measure_fb(int a, int b, int c, bit alt, string tag);
    int n;
    n = exp_ratio(exp_chan(a, b, c), alt);
    set_pins(a, b, c); xtal_sel = alt;
    do_reset();
    for (int i = 0; i < n; i++) osc_edge();
    check(dn == 1'b0, tag, int'(dn), 0);
    osc_edge();
    check(dn == 1'b1, tag, int'(dn), 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    set_pins(0, 0, 0);
    repeat (2) @(negedge clk);
    check(up == 1'b0 && dn == 1'b0, "R9 up/dn in reset", int'({up, dn}), 0);
    check(chan == 4'd0, "R9 chan in reset", int'(chan), 0);
    check(invalid == 1'b1, "R9 invalid in reset", int'(invalid), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(chan == 4'd1 && !invalid, "R1 channel 1 after reset", int'(chan), 1);

    // R1 R2: full pin sweep
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 4; a++) begin
          int e;
          set_pins(a, b, c);
          repeat (2) @(negedge clk);
          e = exp_chan(a, b, c);
          if (e != 0) check(int'(chan) == e && !invalid, "R1 decode", int'(chan), e);
          else check(chan == 4'd0 && invalid, "R2 invalid combo", int'(invalid), 1);
        end

    // R6 R7: reference path, both prescale modes
    set_pins(0, 0, 0); rate_sel = 1'b0; do_reset();
    for (int i = 0; i < 286; i++) ref_edge();
    check(up == 1'b0, "R6 rate0 before edge 287", int'(up), 0);
    ref_edge();
    check(up == 1'b1, "R6 rate0 at edge 287", int'(up), 1);
    rate_sel = 1'b1; do_reset();
    for (int i = 0; i < 573; i++) ref_edge();
    check(up == 1'b0, "R6 rate1 before edge 574", int'(up), 0);
    ref_edge();
    check(up == 1'b1, "R6 rate1 at edge 574", int'(up), 1);
    rate_sel = 1'b0;

    // R4 R5: ratio columns
    measure_fb(0, 0, 0, 1'b0, "R4 ch1 col0");
    measure_fb(1, 2, 0, 1'b0, "R4 ch8 col0");
    measure_fb(2, 1, 1, 1'b1, "R5 ch15 col1");

    // R7 R8: mid-count change waits for terminal count
    set_pins(0, 0, 0); xtal_sel = 1'b0; do_reset();
    osc_edge();
    set_pins(1, 0, 0);
    for (int i = 0; i < 1704; i++) osc_edge();
    check(dn == 1'b0, "R7 old ratio still counting", int'(dn), 0);
    osc_edge();
    check(dn == 1'b1, "R7 old ratio terminal count", int'(dn), 1);
    for (int i = 0; i < 286; i++) ref_edge();
    check(dn == 1'b1 && up == 1'b0, "R8 dn holds", int'({up, dn}), 1);
    ref_edge();
    check(up == 1'b0 && dn == 1'b0, "R8 pair cleared", int'({up, dn}), 0);
    for (int i = 0; i < 3344; i++) osc_edge();
    check(dn == 1'b0, "R7 new ratio before end", int'(dn), 0);
    osc_edge();
    check(dn == 1'b1, "R7 new ratio terminal count", int'(dn), 1);

    // R3: edges while invalid leave nothing behind
    set_pins(3, 0, 0); do_reset();
    for (int i = 0; i < 290; i++) ref_edge();
    check(up == 1'b0 && invalid, "R3 up held while invalid", int'(up), 0);
    set_pins(0, 0, 0);
    repeat (4) @(negedge clk);
    check(up == 1'b0 && !invalid, "R3 no stale up after recovery", int'(up), 0);

    // free run against the model
    set_pins(0, 0, 0); xtal_sel = 1'b0; rate_sel = 1'b0; do_reset();
    for (int i = 0; i < 20000; i++) begin
      ref_clk = i[0];
      osc_clk = i[1];
      if (i == 5000)  xtal_sel = 1'b1;
      if (i == 9000)  rate_sel = 1'b1;
      if (i == 13000) set_pins(2, 2, 1);
      if (i == 14500) set_pins(0, 0, 0);
      @(negedge clk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule